// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for 9-bit words. A writer and a reader sit on separate clocks, and each side has its own enable. The block reports four active-low status flags: empty, full, almost-empty and almost-full. The two almost thresholds are set at run time. While the load control is high, write-side words go into an offset register instead of the queue. Words are taken in a fixed four-step order: the low half of the almost-empty offset first, then its high half, then the low and high halves of the almost-full offset. After the fourth word the order starts again.

The pointers cross between the clock domains as Gray code through two-stage synchronizers. Empty and almost-empty are therefore computed on the read side, and full and almost-full on the write side. Every flag is registered. A flag may report a change late, but it never reports a word that is not there or a free slot that is taken. Read data leaves through an output register. That register holds the last word read while the buffer is empty, even if more read requests arrive.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_ni` is low, the block is reset without waiting for a clock edge. `dout_o` is 0, `empty_n_o` and `aempty_n_o` are 0, and `full_n_o` and `afull_n_o` are 1. Both offsets return to 0 and the load order returns to its first step.
- R2: A write-clock edge stores `din_i` when `wen_i` is 1, `ofs_load_i` is 0 and `full_n_o` is 1. Each read-clock edge with `ren_i` high and `empty_n_o` high puts the oldest stored word on `dout_o`. Words leave in the order they were stored.
- R3: A write attempt while `full_n_o` is 0 is dropped. The queue keeps exactly DEPTH words, and the dropped words never appear on `dout_o`.
- R4: A read attempt while `empty_n_o` is 0 is ignored. `dout_o` keeps the last word read.
- R5: `empty_n_o` is 0 after read edge e exactly when the number of words read up to e equals the number of words written up to three edges before e. The two synchronizer stages and the flag register each take one edge.
- R6: `full_n_o` is 0 after write edge e exactly when the words written up to e, minus the words read up to three edges before e, equal DEPTH.
- R7: `aempty_n_o` is 0 whenever the read side sees n or fewer unread words, where n is the almost-empty offset in force before that edge.
- R8: `afull_n_o` is 0 whenever the write side sees m or fewer free locations, that is, at least DEPTH−m unread words. Here m is the almost-full offset in force before that edge.
- R9: A write edge with both `wen_i` and `ofs_load_i` high does not touch the queue. It writes `din_i` into the offset register in this order: step 0 is the almost-empty low word, step 1 the almost-empty high word, step 2 the almost-full low word and step 3 the almost-full high word. Step 3 is followed by step 0 again. Each offset is the low log2(DEPTH)+1 bits of {high word, low word}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_i | input | 1 | Write enable |
| ofs_load_i | input | 1 | Steers writes into the offset register |
| din_i | input | 9 | Write data or offset word |
| ren_i | input | 1 | Read enable |
| dout_o | output | 9 | Registered read data |
| empty_n_o | output | 1 | Empty flag, active low |
| full_n_o | output | 1 | Full flag, active low |
| aempty_n_o | output | 1 | Almost-empty flag, active low |
| afull_n_o | output | 1 | Almost-full flag, active low |

## Verification
The first pattern writes in a burst and then drains the buffer with read enable held high past empty. This separates correct ordering and the three-edge empty latency from a read that runs past the end. A second burst overfills the buffer and then drains it completely. A dropped write shows up as a missing or extra word, which sets overflow protection apart from plain full-flag timing. Offset loads with nonzero high words, including a fifth load that wraps back to step 0, are each followed by a fill and a drain. These show whether each word lands in the right half of the right offset. A long run of pseudo-random simultaneous reads and writes, and a reset issued mid-run, finish the test.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    // Position in the four-word offset load order
    typedef enum logic [1:0] {
        STEP_AE_LO = 2'd0,
        STEP_AE_HI = 2'd1,
        STEP_AF_LO = 2'd2,
        STEP_AF_HI = 2'd3
    } ofs_step_e;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync
    import pflag_fifo_pkg::*;
#(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = gray_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign bin_o = W'(from_gray(32'(stg_q[STAGES-1])));

endmodule

// File: rtl/pflag_fifo_mem.sv
module pflag_fifo_mem #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          wclk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk_i) begin
        if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/pflag_fifo_wr.sv
module pflag_fifo_wr
    import pflag_fifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          wclk_i,
    input  logic          rst_ni,
    input  logic          wen_i,
    input  logic          ld_i,
    input  logic [DW-1:0] din_i,
    input  logic [CW-1:0] rbin_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [CW-1:0] wgray_o,
    output logic          full_o,
    output logic          afull_o,
    output logic [CW-1:0] ae_ofs_o
);

    localparam int LW = 2 * DW;

    typedef struct packed {
        logic [CW-1:0] ptr;
        logic [CW-1:0] gray;
        logic          full;
        logic          afull;
        ofs_step_e     step;
        logic [CW-1:0] ae_ofs;
        logic [CW-1:0] af_ofs;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic          push_w;
    logic          load_w;
    logic [CW-1:0] used_w;
    logic [CW-1:0] room_w;
    logic [CW-1:0] held_w;
    logic [1:0]    step_w;

    function automatic logic [CW-1:0] put_lo(input logic [CW-1:0] cur, input logic [DW-1:0] w);
        logic [LW-1:0] t;
        t          = LW'(cur);
        t[DW-1:0]  = w;
        return CW'(t);
    endfunction

    function automatic logic [CW-1:0] put_hi(input logic [CW-1:0] cur, input logic [DW-1:0] w);
        logic [LW-1:0] t;
        t           = LW'(cur);
        t[LW-1:DW]  = w;
        return CW'(t);
    endfunction

    always_comb begin
        s_d    = s_q;
        push_w = wen_i && !ld_i && !s_q.full;
        load_w = wen_i && ld_i;

        s_d.ptr  = s_q.ptr + CW'(push_w);
        s_d.gray = CW'(to_gray(32'(s_d.ptr)));
        used_w   = s_d.ptr - rbin_i;
        room_w   = CW'(DEPTH) - used_w;
        s_d.full  = (used_w == CW'(DEPTH));
        s_d.afull = (room_w <= s_q.af_ofs);

        if (load_w) begin
            unique case (s_q.step)
                STEP_AE_LO: s_d.ae_ofs = put_lo(s_q.ae_ofs, din_i);
                STEP_AE_HI: s_d.ae_ofs = put_hi(s_q.ae_ofs, din_i);
                STEP_AF_LO: s_d.af_ofs = put_lo(s_q.af_ofs, din_i);
                STEP_AF_HI: s_d.af_ofs = put_hi(s_q.af_ofs, din_i);
            endcase
            s_d.step = ofs_step_e'(s_q.step + 2'd1);
        end
    end

    always_ff @(posedge wclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{ptr: '0, gray: '0, full: 1'b0, afull: 1'b0,
                      step: STEP_AE_LO, ae_ofs: '0, af_ofs: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign we_o     = push_w;
    assign waddr_o  = s_q.ptr[AW-1:0];
    assign wgray_o  = s_q.gray;
    assign full_o   = s_q.full;
    assign afull_o  = s_q.afull;
    assign ae_ofs_o = s_q.ae_ofs;
    assign held_w   = s_q.ptr - rbin_i;
    assign step_w   = s_q.step;

    // R3: the write side never holds more than DEPTH words
    p_count_bound_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        held_w <= CW'(DEPTH));

    // R8: full lies inside the almost-full region
    p_full_in_afull_r8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        s_q.full |-> s_q.afull);

    // R9: each offset load advances the order by one step
    p_step_advance_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        (wen_i && ld_i) |=> (step_w == $past(step_w) + 2'd1));

    // R9: a load cycle does not move the write pointer
    p_load_no_push_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        ld_i |=> $stable(s_q.ptr));

endmodule

// File: rtl/pflag_fifo_rd.sv
module pflag_fifo_rd
    import pflag_fifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          rclk_i,
    input  logic          rst_ni,
    input  logic          ren_i,
    input  logic [CW-1:0] wbin_i,
    input  logic [CW-1:0] ae_ofs_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [CW-1:0] rgray_o,
    output logic [DW-1:0] dout_o,
    output logic          empty_o,
    output logic          aempty_o
);

    typedef struct packed {
        logic [CW-1:0] ptr;
        logic [CW-1:0] gray;
        logic          empty;
        logic          aempty;
        logic [DW-1:0] dout;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic          pop_w;
    logic [CW-1:0] avail_w;
    logic [CW-1:0] seen_w;

    always_comb begin
        s_d   = s_q;
        pop_w = ren_i && !s_q.empty;

        s_d.ptr    = s_q.ptr + CW'(pop_w);
        s_d.gray   = CW'(to_gray(32'(s_d.ptr)));
        avail_w    = wbin_i - s_d.ptr;
        s_d.empty  = (avail_w == '0);
        s_d.aempty = (avail_w <= ae_ofs_i);
        if (pop_w) begin
            s_d.dout = rdata_i;
        end
    end

    always_ff @(posedge rclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{ptr: '0, gray: '0, empty: 1'b1, aempty: 1'b1, dout: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign raddr_o  = s_q.ptr[AW-1:0];
    assign rgray_o  = s_q.gray;
    assign dout_o   = s_q.dout;
    assign empty_o  = s_q.empty;
    assign aempty_o = s_q.aempty;
    assign seen_w   = wbin_i - s_q.ptr;

    // R4: the read pointer never runs past the synchronized write pointer
    p_no_underrun_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        seen_w <= CW'(DEPTH));

    // R4: output register holds while empty
    p_hold_when_empty_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        s_q.empty |=> $stable(s_q.dout));

    // R7: empty lies inside the almost-empty region
    p_empty_in_aempty_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        s_q.empty |-> s_q.aempty);

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    parameter int SYNC  = 2
) (
    input  logic          wclk_i,
    input  logic          rclk_i,
    input  logic          rst_ni,
    input  logic          wen_i,
    input  logic          ofs_load_i,
    input  logic [DW-1:0] din_i,
    input  logic          ren_i,
    output logic [DW-1:0] dout_o,
    output logic          empty_n_o,
    output logic          full_n_o,
    output logic          aempty_n_o,
    output logic          afull_n_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          we_w;
    logic [AW-1:0] waddr_w;
    logic [AW-1:0] raddr_w;
    logic [DW-1:0] rdata_w;
    logic [CW-1:0] wgray_w, rgray_w;
    logic [CW-1:0] wbin_in_r, rbin_in_w;
    logic [CW-1:0] ae_ofs_w;
    logic          full_w, afull_w, empty_w, aempty_w;

    pflag_fifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk_i  (wclk_i),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (din_i),
        .raddr_i (raddr_w),
        .rdata_o (rdata_w)
    );

    pflag_fifo_sync #(.W(CW), .STAGES(SYNC)) u_sync_r2w (
        .clk_i  (wclk_i),
        .rst_ni (rst_ni),
        .gray_i (rgray_w),
        .bin_o  (rbin_in_w)
    );

    pflag_fifo_sync #(.W(CW), .STAGES(SYNC)) u_sync_w2r (
        .clk_i  (rclk_i),
        .rst_ni (rst_ni),
        .gray_i (wgray_w),
        .bin_o  (wbin_in_r)
    );

    pflag_fifo_wr #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .wclk_i   (wclk_i),
        .rst_ni   (rst_ni),
        .wen_i    (wen_i),
        .ld_i     (ofs_load_i),
        .din_i    (din_i),
        .rbin_i   (rbin_in_w),
        .we_o     (we_w),
        .waddr_o  (waddr_w),
        .wgray_o  (wgray_w),
        .full_o   (full_w),
        .afull_o  (afull_w),
        .ae_ofs_o (ae_ofs_w)
    );

    pflag_fifo_rd #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rd (
        .rclk_i   (rclk_i),
        .rst_ni   (rst_ni),
        .ren_i    (ren_i),
        .wbin_i   (wbin_in_r),
        .ae_ofs_i (ae_ofs_w),
        .rdata_i  (rdata_w),
        .raddr_o  (raddr_w),
        .rgray_o  (rgray_w),
        .dout_o   (dout_o),
        .empty_o  (empty_w),
        .aempty_o (aempty_w)
    );

    assign empty_n_o  = !empty_w;
    assign full_n_o   = !full_w;
    assign aempty_n_o = !aempty_w;
    assign afull_n_o  = !afull_w;

endmodule

// File: tb/test_pflag_fifo.sv
module test_pflag_fifo;

    localparam int DW    = 9;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen = 1'b0, ld = 1'b0, ren = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          empty_n, full_n, aempty_n, afull_n;

    always #10 clk = ~clk;

    pflag_fifo #(.DW(DW), .DEPTH(DEPTH)) i_pflag_fifo (
        .wclk_i     (clk),
        .rclk_i     (clk),
        .rst_ni     (rst_n),
        .wen_i      (wen),
        .ofs_load_i (ld),
        .din_i      (din),
        .ren_i      (ren),
        .dout_o     (dout),
        .empty_n_o  (empty_n),
        .full_n_o   (full_n),
        .aempty_n_o (aempty_n),
        .afull_n_o  (afull_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string dtag = "R2";

    // reference model state
    int            mW, mR;
    int            wh[3], rh[3];
    logic [DW-1:0] mq[$];
    logic [DW-1:0] mdout;
    bit            mfull, mafull, mempty, maempty;
    int            step;
    logic [DW-1:0] ae_lo, ae_hi, af_lo, af_hi;

    function automatic int ofs_of(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
        return int'({hi, lo}) % (1 << CW);
    endfunction

    task automatic model_reset();
        mW = 0; mR = 0;
        for (int i = 0; i < 3; i++) begin wh[i] = 0; rh[i] = 0; end
        mq.delete();
        mdout = '0;
        mfull = 0; mafull = 0; mempty = 1; maempty = 1;
        step = 0; ae_lo = '0; ae_hi = '0; af_lo = '0; af_hi = '0;
    endtask

    task automatic model_edge();
        bit wacc, racc;
        int used, avail, n, m;
        wacc = wen && !ld && !mfull;
        racc = ren && !mempty;
        if (wacc) mq.push_back(din);
        if (racc) mdout = mq.pop_front();
        mW += int'(wacc);
        mR += int'(racc);
        used  = mW - rh[2];
        avail = wh[2] - mR;
        n = ofs_of(ae_hi, ae_lo);
        m = ofs_of(af_hi, af_lo);
        mfull   = (used == DEPTH);
        mafull  = ((DEPTH - used) <= m);
        mempty  = (avail == 0);
        maempty = (avail <= n);
        wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = mW;
        rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = mR;
        if (wen && ld) begin
            case (step)
                0: ae_lo = din;
                1: ae_hi = din;
                2: af_lo = din;
                default: af_hi = din;
            endcase
            step = (step + 1) % 4;
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(dtag, "dout", int'(dout), int'(mdout));
        check("R5", "empty_n", int'(empty_n), int'(!mempty));
        check("R6", "full_n", int'(full_n), int'(!mfull));
        check("R7", "aempty_n", int'(aempty_n), int'(!maempty));
        check("R8", "afull_n", int'(afull_n), int'(!mafull));
    endtask

    task automatic cyc(input bit w, input bit l, input logic [DW-1:0] d, input bit r);
        wen = w; ld = l; din = d; ren = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic check_reset_state();
        check("R1", "reset dout", int'(dout), 0);
        check("R1", "reset empty_n", int'(empty_n), 0);
        check("R1", "reset full_n", int'(full_n), 1);
        check("R1", "reset aempty_n", int'(aempty_n), 0);
        check("R1", "reset afull_n", int'(afull_n), 1);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 0, '0, 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // burst write then drain past empty
        dtag = "R2";
        for (int i = 0; i < 5; i++) cyc(1, 0, 9'(9'h101 + i), 0);
        idle(4);
        for (int i = 0; i < 5; i++) cyc(0, 0, '0, 1);
        dtag = "R4";
        for (int i = 0; i < 6; i++) cyc(0, 0, '0, 1);

        // overfill then drain
        dtag = "R3";
        for (int i = 0; i < 22; i++) cyc(1, 0, 9'(9'h0A0 + i), 0);
        idle(4);
        for (int i = 0; i < 22; i++) cyc(0, 0, '0, 1);

        // load offsets: ae = 3 (high word truncated away), af = 4
        dtag = "R9";
        cyc(1, 1, 9'd3, 0);
        cyc(1, 1, 9'h100, 0);
        cyc(1, 1, 9'd4, 0);
        cyc(1, 1, 9'd0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 0, 9'(9'h040 + i), 0);
            cyc(0, 0, '0, 0);
        end
        idle(3);
        for (int i = 0; i < DEPTH + 2; i++) begin
            cyc(0, 0, '0, 1);
            cyc(0, 0, '0, 0);
        end

        // five loads: the fifth wraps to the almost-empty low word
        cyc(1, 1, 9'd1, 0);
        cyc(1, 1, 9'd0, 0);
        cyc(1, 1, 9'd2, 0);
        cyc(1, 1, 9'd0, 0);
        cyc(1, 1, 9'd6, 0);
        for (int i = 0; i < 12; i++) cyc(1, 0, 9'(9'h150 + i), 0);
        idle(3);
        for (int i = 0; i < 14; i++) cyc(0, 0, '0, 1);

        // mixed traffic
        dtag = "R2";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[3], 0, lfsr[8:0], lfsr[5] & ~(lfsr[1] & lfsr[7]));
        end

        // asynchronous reset in mid run
        for (int i = 0; i < 6; i++) cyc(1, 0, 9'(9'h1F0 + i), 1);
        #3 rst_n = 1'b0;
        #2 check_reset_state();
        model_reset();
        wen = 0; ld = 0; ren = 0;
        @(negedge clk);
        rst_n = 1'b1;
        dtag = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 0, 9'(9'h0C0 + i), 0);
        idle(3);
        for (int i = 0; i < 5; i++) cyc(0, 0, '0, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule